// File: doc/BRIEF.md
# UART Interrupt Identification and Prioritization

This block collects the interrupt conditions of a UART and presents them in a read-only identification word that follows the classic 16550 layout. Five interrupt sources are ranked by priority: line status errors, received data, receive timeout, transmit request and modem status change. Only the highest-ranked active source appears in the low four bits. An active-low pending flag sits in bit 0.

A sixth indication, autobaud lock, is reported in a bit of its own. It is not part of the priority code and does not affect the pending flag. The word also carries a two-bit FIFO mode field. Every source has an enable bit. A single interrupt line is raised whenever an enabled encoded source is pending or the enabled lock flag is set.

The receive timeout and the transmit request are latched inside the block. The timeout latch clears when a character arrives, when the receive buffer is read, or when FIFO mode is left. The transmit latch is armed on a rising transmit condition. It clears on a write to the transmitter, or on a read of this word while the transmit request is the source being reported.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the word reads 0x00000001 and `irq` is low.
- R2: An enabled line-status error is reported as code 0110 in bits 3:0, ahead of every other source.
- R3: Received data (code 0100) is reported ahead of a receive timeout (code 1100), and both are reported ahead of the transmit request.
- R4: A transmit request (code 0010) is reported ahead of a modem status change (code 0000).
- R5: When no enabled encoded source is active, bit 0 is 1 and bits 3:1 are 000.
- R6: A receive timeout is latched only in FIFO mode. The latch clears on `rx_push`, on `rx_pop`, or when `fifo_en` is low.
- R7: The transmit request latch is set on a 0-to-1 change of `tx_cond`. It is cleared by `tx_write`, or by `rd_strobe` while bits 3:0 read 0010. A read while another source is reported leaves it set.
- R8: Bits 7:6 read 11 when `fifo_en` is high and 00 when it is low. They never take the values 01 or 10.
- R9: Bit 4 shows the enabled autobaud lock flag and changes neither bit 0 nor bits 3:1. Bit 5 and bits 31:8 always read 0.
- R10: The enable bits of `src_en` select the sources that can be reported: bit 0 receive data and timeout, bit 1 transmit, bit 2 line status, bit 3 modem, bit 4 autobaud lock. `irq` is high exactly when bit 0 is 0 or bit 4 is 1.
- R11: Every output reflects the inputs two clock edges after they are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO mode selected |
| line_err | input | 1 | One or more receive error flags are set |
| rx_avail | input | 1 | Receive threshold reached (FIFO mode) or holding byte present |
| rx_timeout | input | 1 | Pulse from the external character timeout counter |
| rx_push | input | 1 | A new character entered the receive path |
| rx_pop | input | 1 | Receive data was read |
| tx_cond | input | 1 | Transmit FIFO at least half empty, or holding register sent |
| tx_write | input | 1 | New data written to the transmitter |
| modem_chg | input | MSR_W | Modem input change flags |
| abl_lock | input | 1 | Autobaud lock flag |
| src_en | input | 5 | Per-source interrupt enables |
| rd_strobe | input | 1 | Read of the identification word |
| iir | output | REG_W | Identification word |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach is a read that must leave a latched transmit request alone. This needs a transmit request pending underneath a higher-priority line error at the moment of the read. The stimulus arms the transmit latch with a rising `tx_cond` while `line_err` is already high, strobes a read, and then drops the line error so that the surviving transmit code has to appear. The timeout latch is handled the same way: it is set, then raced against a character arrival, a receive read and leaving FIFO mode.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    ID_NONE   = 4'b0001,
    ID_LINE   = 4'b0110,
    ID_RXDATA = 4'b0100,
    ID_RXTO   = 4'b1100,
    ID_TXREQ  = 4'b0010,
    ID_MODEM  = 4'b0000
  } irq_id_e;

  // Encoded sources, index 0 is the highest priority
  localparam int NUM_SRC    = 5;
  localparam int SRC_LINE   = 0;
  localparam int SRC_RXDATA = 1;
  localparam int SRC_RXTO   = 2;
  localparam int SRC_TX     = 3;
  localparam int SRC_MODEM  = 4;

  // Enable vector positions
  localparam int EN_W     = 5;
  localparam int EN_RX    = 0;
  localparam int EN_TX    = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;
  localparam int EN_ABL   = 4;

  typedef struct packed {
    logic [NUM_SRC-1:0] req;
    logic               abl;
    logic               fifo;
  } irq_state_t;

  function automatic irq_id_e src_code(input int idx);
    irq_id_e c;
    case (idx)
      SRC_LINE:   c = ID_LINE;
      SRC_RXDATA: c = ID_RXDATA;
      SRC_RXTO:   c = ID_RXTO;
      SRC_TX:     c = ID_TXREQ;
      default:    c = ID_MODEM;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/uart_irq_src.sv
module uart_irq_src
  import uart_irq_pkg::*;
#(
  parameter int MSR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic             line_err,
  input  logic             rx_avail,
  input  logic             rx_timeout,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             tx_cond,
  input  logic             tx_write,
  input  logic             tx_ack,
  input  logic [MSR_W-1:0] modem_chg,
  input  logic             abl_lock,
  input  logic [EN_W-1:0]  src_en,
  output irq_state_t       st
);

  logic            line_q, rxav_q, msr_q, abl_q, fifo_q;
  logic            to_pend, tx_pend, tx_cond_d;
  logic [EN_W-1:0] en_q;
  logic            tx_rise;

  assign tx_rise = tx_cond & ~tx_cond_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q    <= 1'b0;
      rxav_q    <= 1'b0;
      msr_q     <= 1'b0;
      abl_q     <= 1'b0;
      fifo_q    <= 1'b0;
      en_q      <= '0;
      to_pend   <= 1'b0;
      tx_pend   <= 1'b0;
      tx_cond_d <= 1'b0;
    end else begin
      line_q    <= line_err;
      rxav_q    <= rx_avail;
      msr_q     <= |modem_chg;
      abl_q     <= abl_lock;
      fifo_q    <= fifo_en;
      en_q      <= src_en;
      tx_cond_d <= tx_cond;
      // timeout survives only in FIFO mode; a new char or a read services it
      to_pend   <= fifo_en & ~rx_push & ~rx_pop & (to_pend | rx_timeout);
      // clearing events take precedence over a new rising condition
      if (tx_write || tx_ack) tx_pend <= 1'b0;
      else if (tx_rise)       tx_pend <= 1'b1;
    end
  end

  always_comb begin
    st.req             = '0;
    st.req[SRC_LINE]   = line_q  & en_q[EN_LINE];
    st.req[SRC_RXDATA] = rxav_q  & en_q[EN_RX];
    st.req[SRC_RXTO]   = to_pend & en_q[EN_RX];
    st.req[SRC_TX]     = tx_pend & en_q[EN_TX];
    st.req[SRC_MODEM]  = msr_q   & en_q[EN_MODEM];
    st.abl             = abl_q   & en_q[EN_ABL];
    st.fifo            = fifo_q;
  end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] req,
  output irq_id_e            id,
  output logic               pending
);

  // walk from lowest to highest so the highest active source is left last
  always_comb begin
    id      = ID_NONE;
    pending = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        id      = src_code(i);
        pending = 1'b1;
      end
    end
  end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int MSR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic             line_err,
  input  logic             rx_avail,
  input  logic             rx_timeout,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             tx_cond,
  input  logic             tx_write,
  input  logic [MSR_W-1:0] modem_chg,
  input  logic             abl_lock,
  input  logic [4:0]       src_en,
  input  logic             rd_strobe,
  output logic [REG_W-1:0] iir,
  output logic             irq
);

  localparam int RSV_W = REG_W - 8;

  irq_state_t st;
  irq_id_e    id;
  logic       pending;
  logic       tx_ack;
  logic [REG_W-1:0] iir_q;
  logic       irq_q;

  // a read that observed the transmit code acknowledges it
  assign tx_ack = rd_strobe & (iir_q[3:0] == ID_TXREQ);

  uart_irq_src #(.MSR_W(MSR_W)) u_src (
    .clk        (clk),
    .rst        (rst),
    .fifo_en    (fifo_en),
    .line_err   (line_err),
    .rx_avail   (rx_avail),
    .rx_timeout (rx_timeout),
    .rx_push    (rx_push),
    .rx_pop     (rx_pop),
    .tx_cond    (tx_cond),
    .tx_write   (tx_write),
    .tx_ack     (tx_ack),
    .modem_chg  (modem_chg),
    .abl_lock   (abl_lock),
    .src_en     (src_en),
    .st         (st)
  );

  uart_irq_prio u_prio (
    .req     (st.req),
    .id      (id),
    .pending (pending)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iir_q <= {{RSV_W{1'b0}}, 8'h01};
      irq_q <= 1'b0;
    end else begin
      iir_q <= {{RSV_W{1'b0}}, {2{st.fifo}}, 1'b0, st.abl, id};
      irq_q <= pending | st.abl;
    end
  end

  assign iir = iir_q;
  assign irq = irq_q;

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
  parameter int REG_W = 32,
  parameter int MSR_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             fifo_en,
  input logic             line_err,
  input logic [4:0]       src_en,
  input logic [REG_W-1:0] iir,
  input logic             irq
);

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (iir[REG_W-1:8] == '0) && !iir[5]);                                   // R9

  AST_FIFO_FIELD: assert property (@(posedge clk) disable iff (rst)
    (iir[7:6] == 2'b00) || (iir[7:6] == 2'b11));                          // R8

  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (rst)
    iir[0] |-> (iir[3:1] == 3'b000));                                     // R5

  AST_IRQ_LINE: assert property (@(posedge clk) disable iff (rst)
    irq == (!iir[0] || iir[4]));                                          // R10

  AST_LINE_FIRST: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(line_err && src_en[2])) |=> (iir[3:0] == 4'b0110)); // R2

  AST_NO_TO_NONFIFO: assert property (@(posedge clk) disable iff (rst)
    (!fifo_en && $past(!fifo_en)) |=> (iir[3:0] != 4'b1100));            // R6

endmodule

bind uart_irq_ident uart_irq_ident_chk #(.REG_W(REG_W), .MSR_W(MSR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .fifo_en  (fifo_en),
  .line_err (line_err),
  .src_en   (src_en),
  .iir      (iir),
  .irq      (irq)
);

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;

  localparam int REG_W = 32;
  localparam int MSR_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             fifo_en = 0, line_err = 0, rx_avail = 0, rx_timeout = 0;
  logic             rx_push = 0, rx_pop = 0, tx_cond = 0, tx_write = 0;
  logic [MSR_W-1:0] modem_chg = '0;
  logic             abl_lock = 0;
  logic [4:0]       src_en = 5'b11111;
  logic             rd_strobe = 0;
  logic [REG_W-1:0] iir;
  logic             irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;  // 50 MHz

  uart_irq_ident #(.REG_W(REG_W), .MSR_W(MSR_W)) dut (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .line_err(line_err),
    .rx_avail(rx_avail), .rx_timeout(rx_timeout), .rx_push(rx_push),
    .rx_pop(rx_pop), .tx_cond(tx_cond), .tx_write(tx_write),
    .modem_chg(modem_chg), .abl_lock(abl_lock), .src_en(src_en),
    .rd_strobe(rd_strobe), .iir(iir), .irq(irq)
  );

  function automatic logic [REG_W-1:0] word(input logic f, input logic a, input logic [3:0] c);
    return {{(REG_W-8){1'b0}}, {2{f}}, 1'b0, a, c};
  endfunction

  task automatic check(input string req, input logic [REG_W-1:0] exp_w, input logic exp_irq);
    n_vec++;
    if (iir !== exp_w || irq !== exp_irq) begin
      n_bad++;
      $display("FAIL %s: iir=%h irq=%b expected iir=%h irq=%b", req, iir, irq, exp_w, exp_irq);
    end
  endtask

  // inputs change at a falling edge; outputs follow two rising edges later
  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_rd();    rd_strobe = 1;  @(negedge clk); rd_strobe = 0;  endtask
  task automatic pulse_txw();   tx_write = 1;   @(negedge clk); tx_write = 0;   endtask
  task automatic pulse_to();    rx_timeout = 1; @(negedge clk); rx_timeout = 0; endtask
  task automatic pulse_push();  rx_push = 1;    @(negedge clk); rx_push = 0;    endtask
  task automatic pulse_pop();   rx_pop = 1;     @(negedge clk); rx_pop = 0;     endtask

  task automatic t_reset();
    check("R1 reset value", word(0, 0, 4'b0001), 0);
    settle();
    check("R5 idle non-fifo", word(0, 0, 4'b0001), 0);
  endtask

  task automatic t_fifo_field();
    fifo_en = 1; settle();
    check("R8 fifo mode field 11", word(1, 0, 4'b0001), 0);
    fifo_en = 0; settle();
    check("R8 non-fifo field 00", word(0, 0, 4'b0001), 0);
  endtask

  task automatic t_timeout();
    pulse_to(); settle();
    check("R6 timeout ignored non-fifo", word(0, 0, 4'b0001), 0);
    fifo_en = 1; @(negedge clk);
    pulse_to(); settle();
    check("R6 timeout latched", word(1, 0, 4'b1100), 1);
    rx_avail = 1; settle();
    check("R3 rx data over timeout", word(1, 0, 4'b0100), 1);
    rx_avail = 0; settle();
    check("R3 timeout after rx data drops", word(1, 0, 4'b1100), 1);
    pulse_push(); settle();
    check("R6 new char clears timeout", word(1, 0, 4'b0001), 0);
    pulse_to(); pulse_pop(); settle();
    check("R6 receive read clears timeout", word(1, 0, 4'b0001), 0);
    pulse_to(); fifo_en = 0; settle();
    check("R6 leaving fifo clears timeout", word(0, 0, 4'b0001), 0);
    settle();
    check("R6 timeout stays clear", word(0, 0, 4'b0001), 0);
  endtask

  task automatic t_tx_modem();
    tx_cond = 1; settle();
    check("R7 tx request on rising cond", word(0, 0, 4'b0010), 1);
    modem_chg = 4'b0100; settle();
    check("R4 tx over modem", word(0, 0, 4'b0010), 1);
    pulse_rd(); settle();
    check("R7 read clears tx, modem remains", word(0, 0, 4'b0000), 1);
    modem_chg = '0; settle();
    check("R7 tx stays clear with cond held", word(0, 0, 4'b0001), 0);
    tx_cond = 0; @(negedge clk); tx_cond = 1; settle();
    check("R7 re-armed by new rise", word(0, 0, 4'b0010), 1);
    pulse_txw(); settle();
    check("R7 write clears tx", word(0, 0, 4'b0001), 0);
    tx_cond = 0; @(negedge clk);
    rx_avail = 1; tx_cond = 1; settle();
    check("R3 rx data over tx", word(0, 0, 4'b0100), 1);
    rx_avail = 0; settle();
    check("R3 tx appears after rx data", word(0, 0, 4'b0010), 1);
    pulse_txw(); tx_cond = 0; settle();
  endtask

  task automatic t_line_hidden_tx();
    line_err = 1; rx_avail = 1; modem_chg = 4'b0001; @(negedge clk);
    tx_cond = 1; settle();
    check("R2 line error over all", word(0, 0, 4'b0110), 1);
    pulse_rd(); line_err = 0; rx_avail = 0; modem_chg = '0; settle();
    check("R7 read under line error keeps tx", word(0, 0, 4'b0010), 1);
    pulse_rd(); settle();
    check("R7 second read clears tx", word(0, 0, 4'b0001), 0);
    tx_cond = 0; settle();
  endtask

  task automatic t_enables();
    src_en = 5'b00000; rx_avail = 1; line_err = 1; settle();
    check("R10 disabled sources hidden", word(0, 0, 4'b0001), 0);
    src_en = 5'b00001; settle();
    check("R10 only rx enabled", word(0, 0, 4'b0100), 1);
    src_en = 5'b11111; rx_avail = 0; line_err = 0; settle();
    check("R11 two-edge latency idle", word(0, 0, 4'b0001), 0);
    line_err = 1;
    @(posedge clk); @(negedge clk);
    check("R11 no change after one edge", word(0, 0, 4'b0001), 0);
    @(posedge clk); @(negedge clk);
    check("R11 change after two edges", word(0, 0, 4'b0110), 1);
    line_err = 0; settle();
  endtask

  task automatic t_abl();
    abl_lock = 1; settle();
    check("R9 lock bit alone, no pending", word(0, 1, 4'b0001), 1);
    line_err = 1; fifo_en = 1; settle();
    check("R9 lock bit with line code", word(1, 1, 4'b0110), 1);
    line_err = 0; src_en[4] = 0; settle();
    check("R10 lock disabled", word(1, 0, 4'b0001), 0);
    abl_lock = 0; src_en = 5'b11111; fifo_en = 0; settle();
    check("R9 lock cleared", word(0, 0, 4'b0001), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_fifo_field();
    t_timeout();
    t_tx_modem();
    t_line_hidden_tx();
    t_enables();
    t_abl();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule